// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Indicator

This block compares two divided pulse trains inside a frequency synthesizer: the divided reference and the divided oscillator. Each input passes through a synchronizer and a rising-edge detector. A three-state machine then turns the order of the edges into a pump command. If the reference edge comes first, the block drives "up". If the oscillator edge comes first, it drives "down". The command clears when the other edge arrives. The command is given in two forms: a two-bit code for an on-chip pump, where zero means high impedance, and a pair of active-high lines for an external pump.

A second state machine measures how long each pump command lasts. It declares lock after a run of narrow comparisons and drops lock as soon as any command grows too wide. A run input gates the whole loop. While run is low, the block parks: the pump code is high impedance, the pump-enable output is low, lock is cleared, and edges are ignored. When run returns, comparison restarts with both flags cleared. Two monitor outputs expose the synchronized comparator inputs.

Core state names: `CMP_PARK`, `CMP_IDLE`, `CMP_UP`, `CMP_DN`. Transitions:
- park→idle when run is high.
- idle→up on a reference edge alone.
- idle→down on an oscillator edge alone.
- idle→idle when both edges arrive together.
- up→idle on an oscillator edge.
- down→idle on a reference edge.
- any state→park when run is low.

Lock state names: `LK_HUNT`, `LK_QUAL`, `LK_LOCKED`. Transitions:
- hunt→qual on a narrow comparison.
- qual→locked when the narrow count reaches `LOCK_COUNT`.
- qual/locked→hunt on a wide command.
- any state→hunt when run is low.

Top module: `pfd_lock_top`

## Requirements
- R1: During and right after reset, `pump_code` is 2'b00 (high impedance), `ext_up`, `ext_dn`, `pump_en` and `lock_o` are all low.
- R2: `mon_ref` and `mon_vco` equal `ref_in` and `vco_in` delayed by `SYNC_STAGES` clocks.
- R3: A reference rising edge with no pending flag makes `pump_code` 2'b01 and `ext_up` high, `SYNC_STAGES`+1 clocks after the edge is sampled. Both return to 2'b00 and low when the oscillator edge is processed, so the command lasts exactly as many clocks as the edges are apart.
- R4: An oscillator rising edge with no pending flag makes `pump_code` 2'b10 and `ext_dn` high, until the next reference edge is processed.
- R5: Rising edges of both inputs in the same clock leave `pump_code` at 2'b00. This counts as a narrow comparison of width zero.
- R6: A further rising edge of the leading input while its flag is set has no effect: the command stays in place until the other input's edge.
- R7: `lock_o` rises after `LOCK_COUNT` consecutive comparisons whose command lasted fewer than `WIDE_LIMIT` clocks, and not earlier.
- R8: When a command reaches `WIDE_LIMIT` clocks, `lock_o` falls in that same clock, without waiting for the command to end. The narrow-comparison count restarts from zero.
- R9: One clock after `run_en` is sampled low, `pump_code` is 2'b00 and `ext_up`, `ext_dn`, `pump_en` and `lock_o` are low. Input edges are ignored while `run_en` stays low.
- R10: When `run_en` returns high, `pump_en` rises with `pump_code` at 2'b00. The first new edge starts a fresh command, with no flag carried over from before the park.
- R11: `ext_up` and `ext_dn` are never high together, and neither switches directly to the other in consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High to operate; low parks the loop |
| ref_in | input | 1 | Divided reference pulse |
| vco_in | input | 1 | Divided oscillator pulse |
| pump_code | output | 2 | On-chip pump drive: 00 high-Z, 01 up, 10 down |
| ext_up | output | 1 | External pump up command |
| ext_dn | output | 1 | External pump down command |
| pump_en | output | 1 | Pump control; low while parked |
| lock_o | output | 1 | High when locked |
| mon_ref | output | 1 | Synchronized reference monitor |
| mon_vco | output | 1 | Synchronized oscillator monitor |

## Verification
The bench builds the block with `SYNC_STAGES` = 2, `WIDE_LIMIT` = 6 and `LOCK_COUNT` = 4. Because the width limit is small, short edge gaps can land on either side of the narrow/wide boundary: a 5-clock command counts as narrow, and a 6-clock command drops lock. The bench also samples the exact clock in which lock falls, before the late edge arrives. The low lock count lets a few comparisons show both the "not yet locked" step and the "locked" step, plus the restart of the count after a wide command.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PUMP_HIZ = 2'b00,
        PUMP_UP  = 2'b01,
        PUMP_DN  = 2'b10
    } pump_code_e;

    typedef enum logic [1:0] {
        CMP_PARK,
        CMP_IDLE,
        CMP_UP,
        CMP_DN
    } cmp_state_e;

    typedef enum logic [1:0] {
        LK_HUNT,
        LK_QUAL,
        LK_LOCKED
    } lock_state_e;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign level = sync_q[STAGES-1];
    assign rise  = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ref_rise,
    input  logic       vco_rise,
    output logic [1:0] pump_code,
    output logic       ext_up,
    output logic       ext_dn,
    output logic       pump_en,
    output logic       active,
    output logic       cmp_done
);

    cmp_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = CMP_PARK;
        end else begin
            unique case (state_q)
                CMP_PARK: state_d = CMP_IDLE;
                CMP_IDLE: begin
                    if (ref_rise && vco_rise) state_d = CMP_IDLE;
                    else if (ref_rise)        state_d = CMP_UP;
                    else if (vco_rise)        state_d = CMP_DN;
                end
                CMP_UP:   if (vco_rise) state_d = CMP_IDLE;
                CMP_DN:   if (ref_rise) state_d = CMP_IDLE;
                default:  state_d = CMP_PARK;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMP_PARK;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        pump_code = PUMP_HIZ;
        ext_up    = 1'b0;
        ext_dn    = 1'b0;
        pump_en   = 1'b1;
        active    = 1'b0;
        cmp_done  = 1'b0;
        unique case (state_q)
            CMP_PARK: pump_en = 1'b0;
            CMP_IDLE: cmp_done = run && ref_rise && vco_rise;
            CMP_UP: begin
                pump_code = PUMP_UP;
                ext_up    = 1'b1;
                active    = 1'b1;
                cmp_done  = run && vco_rise;
            end
            CMP_DN: begin
                pump_code = PUMP_DN;
                ext_dn    = 1'b1;
                active    = 1'b1;
                cmp_done  = run && ref_rise;
            end
            default: pump_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfd_lock_fsm.sv
module pfd_lock_fsm
    import pfd_pkg::*;
#(
    parameter int WIDE_LIMIT = 8,
    parameter int LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic active,
    input  logic cmp_done,
    output logic lock_o
);

    localparam int PW_W   = $clog2(WIDE_LIMIT + 1);
    localparam int GC_W   = $clog2(LOCK_COUNT + 1);
    localparam logic [PW_W-1:0] PW_MAX  = PW_W'(WIDE_LIMIT - 1);
    localparam logic [GC_W-1:0] GC_LAST = GC_W'(LOCK_COUNT - 1);

    lock_state_e     state_q, state_d;
    logic [PW_W-1:0] pw_q, pw_d;
    logic [GC_W-1:0] gc_q, gc_d;
    logic            wide, narrow;

    // Width classification of the command in progress
    always_comb begin
        wide   = active && (pw_q >= PW_MAX);
        narrow = cmp_done && !wide;
        pw_d   = pw_q;
        if (!run || !active || cmp_done) pw_d = '0;
        else if (pw_q < PW_MAX)          pw_d = pw_q + 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        gc_d    = gc_q;
        if (!run || wide) begin
            state_d = LK_HUNT;
            gc_d    = '0;
        end else begin
            unique case (state_q)
                LK_HUNT, LK_QUAL: begin
                    if (narrow) begin
                        if (gc_q == GC_LAST) begin
                            state_d = LK_LOCKED;
                            gc_d    = '0;
                        end else begin
                            state_d = LK_QUAL;
                            gc_d    = gc_q + 1'b1;
                        end
                    end
                end
                LK_LOCKED: state_d = LK_LOCKED;
                default:   state_d = LK_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_HUNT;
            pw_q    <= '0;
            gc_q    <= '0;
        end else begin
            state_q <= state_d;
            pw_q    <= pw_d;
            gc_q    <= gc_d;
        end
    end

    // Output
    always_comb begin
        unique case (state_q)
            LK_LOCKED: lock_o = 1'b1;
            default:   lock_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
    parameter int SYNC_STAGES = 2,
    parameter int WIDE_LIMIT  = 8,
    parameter int LOCK_COUNT  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       ref_in,
    input  logic       vco_in,
    output logic [1:0] pump_code,
    output logic       ext_up,
    output logic       ext_dn,
    output logic       pump_en,
    output logic       lock_o,
    output logic       mon_ref,
    output logic       mon_vco
);

    localparam int NCH = 2;

    logic [NCH-1:0] raw_in, lvl, rise;
    logic           active, cmp_done;

    assign raw_in = {vco_in, ref_in};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_sync
            pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (raw_in[c]),
                .level (lvl[c]),
                .rise  (rise[c])
            );
        end
    endgenerate

    assign mon_ref = lvl[0];
    assign mon_vco = lvl[1];

    pfd_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_en),
        .ref_rise  (rise[0]),
        .vco_rise  (rise[1]),
        .pump_code (pump_code),
        .ext_up    (ext_up),
        .ext_dn    (ext_dn),
        .pump_en   (pump_en),
        .active    (active),
        .cmp_done  (cmp_done)
    );

    pfd_lock_fsm #(.WIDE_LIMIT(WIDE_LIMIT), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .active   (active),
        .cmp_done (cmp_done),
        .lock_o   (lock_o)
    );

endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic [1:0] pump_code,
    input logic       ext_up,
    input logic       ext_dn,
    input logic       pump_en,
    input logic       lock_o
);

    p_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (pump_code == 2'b00 && !ext_up && !ext_dn && !pump_en && !lock_o));

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_up && ext_dn));

    p_no_up_to_dn_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_up |=> !ext_dn);

    p_no_dn_to_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dn |=> !ext_up);

    p_lock_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(pump_en));

    p_resume_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_en) |-> (pump_code == 2'b00 && !lock_o));

endmodule

bind pfd_lock_top pfd_lock_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .pump_code (pump_code),
    .ext_up    (ext_up),
    .ext_dn    (ext_dn),
    .pump_en   (pump_en),
    .lock_o    (lock_o)
);

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b1;
    logic       ref_in = 1'b0;
    logic       vco_in = 1'b0;
    logic [1:0] pump_code;
    logic       ext_up, ext_dn, pump_en, lock_o, mon_ref, mon_vco;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pfd_lock_top #(.SYNC_STAGES(2), .WIDE_LIMIT(6), .LOCK_COUNT(4)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ref_in(ref_in), .vco_in(vco_in),
        .pump_code(pump_code), .ext_up(ext_up), .ext_dn(ext_dn), .pump_en(pump_en),
        .lock_o(lock_o), .mon_ref(mon_ref), .mon_vco(mon_vco)
    );

    always #10 clk = ~clk;

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean();
        run_en = 1'b0; ref_in = 1'b0; vco_in = 1'b0;
        step(3);
        run_en = 1'b1;
        step(3);
    endtask

    task automatic pair(input int gap, input bit ref_lead);
        if (gap == 0) begin
            ref_in = 1'b1; vco_in = 1'b1;
        end else begin
            if (ref_lead) ref_in = 1'b1; else vco_in = 1'b1;
            step(gap);
            if (ref_lead) vco_in = 1'b1; else ref_in = 1'b1;
        end
        step(5);
        ref_in = 1'b0; vco_in = 1'b0;
        step(4);
    endtask

    task automatic t_reset();
        step(2);
        chk(pump_code, 0, "R1 code in reset");
        chk(ext_up | ext_dn, 0, "R1 ext in reset");
        chk(pump_en, 0, "R1 pump_en in reset");
        chk(lock_o, 0, "R1 lock in reset");
        rst_n = 1'b1;
        step(3);
    endtask

    task automatic t_monitor();
        clean();
        ref_in = 1'b1;
        step(1);
        chk(mon_ref, 0, "R2 mon_ref after 1 clock");
        step(1);
        chk(mon_ref, 1, "R2 mon_ref after 2 clocks");
        vco_in = 1'b1;
        step(2);
        chk(mon_vco, 1, "R2 mon_vco after 2 clocks");
        clean();
    endtask

    task automatic t_up_lead();
        clean();
        ref_in = 1'b1;
        step(4);
        chk(pump_code, 1, "R3 up code");
        chk(ext_up, 1, "R3 ext_up");
        ref_in = 1'b0;
        step(1);
        ref_in = 1'b1;
        step(3);
        vco_in = 1'b1;
        step(2);
        chk(pump_code, 1, "R6 second ref edge keeps up");
        step(1);
        chk(pump_code, 0, "R3 up cleared by vco edge");
        chk(ext_up, 0, "R3 ext_up cleared");
        clean();
    endtask

    task automatic t_dn_lead();
        clean();
        vco_in = 1'b1;
        step(4);
        chk(pump_code, 2, "R4 down code");
        chk(ext_dn, 1, "R4 ext_dn");
        ref_in = 1'b1;
        step(2);
        chk(ext_dn, 1, "R4 down held until ref edge");
        step(1);
        chk(pump_code, 0, "R4 down cleared");
        clean();
    endtask

    task automatic t_simultaneous();
        clean();
        ref_in = 1'b1; vco_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step(1);
            chk(pump_code, 0, "R5 simultaneous edges stay high-Z");
        end
        clean();
    endtask

    task automatic t_lock_acquire();
        clean();
        pair(2, 1'b1);
        pair(5, 1'b0);
        pair(0, 1'b1);
        chk(lock_o, 0, "R7 no lock after 3 narrow");
        pair(3, 1'b1);
        chk(lock_o, 1, "R7 lock after 4 narrow");
    endtask

    task automatic t_wide_drop();
        t_lock_acquire();
        ref_in = 1'b1;
        step(8);
        chk(lock_o, 1, "R8 lock held at width 5");
        step(1);
        chk(lock_o, 0, "R8 lock dropped at width 6");
        step(1);
        vco_in = 1'b1;
        step(5);
        ref_in = 1'b0; vco_in = 1'b0;
        step(4);
        pair(2, 1'b1);
        pair(2, 1'b1);
        pair(2, 1'b1);
        chk(lock_o, 0, "R8 count restarted");
        pair(2, 1'b1);
        chk(lock_o, 1, "R8 relock after 4 narrow");
    endtask

    task automatic t_park();
        t_lock_acquire();
        ref_in = 1'b1;
        step(5);
        chk(pump_code, 1, "R9 up before park");
        run_en = 1'b0;
        step(1);
        chk(pump_code, 0, "R9 park code");
        chk(pump_en, 0, "R9 park pump_en");
        chk(lock_o, 0, "R9 park lock");
        chk(ext_up | ext_dn, 0, "R9 park ext");
        ref_in = 1'b0;
        step(1);
        vco_in = 1'b1;
        step(4);
        chk(pump_code, 0, "R9 edges ignored while parked");
        vco_in = 1'b0;
        step(4);
        run_en = 1'b1;
        step(1);
        chk(pump_en, 1, "R10 pump_en on resume");
        chk(pump_code, 0, "R10 clean flags on resume");
        step(3);
        chk(pump_code, 0, "R10 no stale flag");
        vco_in = 1'b1;
        step(4);
        chk(pump_code, 2, "R10 fresh down after resume");
        clean();
    endtask

    initial begin
        t_reset();
        t_monitor();
        t_up_lead();
        t_dn_lead();
        t_simultaneous();
        t_lock_acquire();
        t_wide_drop();
        t_park();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule